// File: doc/BRIEF.md
# GPIO Interrupt Cause and Aggregation

This block is the interrupt section of a 32-line general purpose I/O port. The port block hands it the input data after pad synchronization and after any per-pin polarity inversion, along with a per-pin direction vector. From these the block derives two kinds of interrupt source per pin. A level source follows the adjusted input directly. An edge source is latched into a sticky cause register whenever the adjusted input of an input-configured pin goes from 0 to 1. Falling edges are obtained by inverting the pin's polarity upstream.

Software reaches three registers over a simple register bus. These are the edge cause register, an edge mask and a level mask. The two mask registers sit at a parameterized distance from their base offsets. Edge causes are acknowledged by writing 0 to the bits to be cleared. Masked sources are ORed in groups of eight pins onto four registered interrupt outputs, one per group, which feed the chip's main interrupt controller.

Top module: `gpio_irq_agg`

## Requirements
- R1: Out of reset the edge cause, edge mask and level mask registers all read 0 and every group output is 0.
- R2: Register offsets: edge cause at 0x14, edge mask at 0x18 + MASK_OFS, level mask at 0x1C + MASK_OFS. The two masks are written with the full data word. A read of any of the three returns its current value at once. A read of any other offset returns 0, and a write to any other offset changes nothing.
- R3: A pin's level source is its adjusted input ANDed with its level mask bit. It holds no state, so it drops as soon as the input drops.
- R4: On an input pin (direction bit 1 = input), a 0-to-1 change of the adjusted input between consecutive cycles sets that pin's edge cause bit at the next clock edge. The bit stays set while no clearing write arrives.
- R5: A write to the edge cause register clears each bit written as 0 and leaves each bit written as 1 unchanged.
- R6: When a new edge and a clearing write hit the same cause bit in the same cycle, the bit ends up set.
- R7: A pin whose direction bit is 0 (output) never sets its edge cause bit.
- R8: The edge mask gates only the interrupt path. A masked edge is still recorded in the cause register.
- R9: Group output n is the OR of the pending bits 8n to 8n+7, where pending = (adjusted input AND level mask) OR (edge cause AND edge mask).
- R10: Group outputs are registered. Each output reflects the pending condition of the previous cycle.
- R11: The first clock edge after reset only captures the input. A pin already high when reset is released records no edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_adj | input | 32 | Polarity-adjusted, synchronized input data |
| pin_is_in | input | 32 | Direction per pin, 1 = input |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |
| grp_irq | output | 4 | Per-group interrupt, bit n covers pins 8n..8n+7 |

## Verification
The bench targets four corner cases:
- A clearing write landing in the same cycle as a new edge on the same bit. A design that lets the clear win loses that interrupt for good.
- Pins that toggle while set as outputs. A design that ignores direction raises spurious edge causes.
- A pin that is already high at reset release. A design that compares against a zeroed history records a false edge.
- Masked edges. These must still show in the cause register, while pins sitting on group boundaries must drive only their own group output.

A one-cycle error in the output register shows up as group outputs one cycle early or late against the bench model.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    // Base byte offsets of the interrupt registers
    localparam int unsigned CAUSE_OFFSET = 'h14;
    localparam int unsigned EMASK_BASE   = 'h18;
    localparam int unsigned LMASK_BASE   = 'h1C;
endpackage

// File: rtl/gpio_irq_regfile.sv
module gpio_irq_regfile
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int ADDR_W   = 12,
    parameter int MASK_OFS = 0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [NUM_PINS-1:0] bus_wdata,
    input  logic [NUM_PINS-1:0] cause_i,
    output logic                cause_wr_o,
    output logic [NUM_PINS-1:0] edge_mask_o,
    output logic [NUM_PINS-1:0] level_mask_o,
    output logic [NUM_PINS-1:0] bus_rdata
);
    localparam logic [ADDR_W-1:0] A_CAUSE = ADDR_W'(CAUSE_OFFSET);
    localparam logic [ADDR_W-1:0] A_EMASK = ADDR_W'(EMASK_BASE + MASK_OFS);
    localparam logic [ADDR_W-1:0] A_LMASK = ADDR_W'(LMASK_BASE + MASK_OFS);

    typedef struct packed {
        logic [NUM_PINS-1:0] emask;
        logic [NUM_PINS-1:0] lmask;
    } mask_t;

    mask_t s_d, s_q;
    logic  hit_c, hit_e, hit_l;

    always_comb begin
        hit_c = (bus_addr == A_CAUSE);
        hit_e = (bus_addr == A_EMASK);
        hit_l = (bus_addr == A_LMASK);
        s_d   = s_q;
        if (bus_wr && hit_e) s_d.emask = bus_wdata;
        if (bus_wr && hit_l) s_d.lmask = bus_wdata;
    end

    always_comb begin
        bus_rdata = '0;
        if (hit_c)      bus_rdata = cause_i;
        else if (hit_e) bus_rdata = s_q.emask;
        else if (hit_l) bus_rdata = s_q.lmask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cause_wr_o   = bus_wr && hit_c;
    assign edge_mask_o  = s_q.emask;
    assign level_mask_o = s_q.lmask;
endmodule

// File: rtl/gpio_irq_edge.sv
module gpio_irq_edge #(
    parameter int NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_adj,
    input  logic [NUM_PINS-1:0] pin_is_in,
    input  logic                cause_wr,
    input  logic [NUM_PINS-1:0] wr_data,
    output logic [NUM_PINS-1:0] cause_o
);
    typedef struct packed {
        logic [NUM_PINS-1:0] prev;
        logic [NUM_PINS-1:0] cause;
        logic                primed;
    } edge_t;

    edge_t               s_d, s_q;
    logic [NUM_PINS-1:0] rise_w;
    logic [NUM_PINS-1:0] keep_w;

    always_comb begin
        rise_w     = s_q.primed ? (pin_adj & ~s_q.prev & pin_is_in) : '0;
        keep_w     = cause_wr ? wr_data : '1;
        s_d.cause  = (s_q.cause & keep_w) | rise_w;   // a new edge beats the clear
        s_d.prev   = pin_adj;
        s_d.primed = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cause_o = s_q.cause;
endmodule

// File: rtl/gpio_irq_group.sv
module gpio_irq_group #(
    parameter int NUM_PINS = 32,
    parameter int GROUP_W  = 8,
    localparam int NUM_GROUPS = NUM_PINS / GROUP_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PINS-1:0]   pin_adj,
    input  logic [NUM_PINS-1:0]   level_mask,
    input  logic [NUM_PINS-1:0]   cause,
    input  logic [NUM_PINS-1:0]   edge_mask,
    output logic [NUM_GROUPS-1:0] grp_irq
);
    typedef struct packed {
        logic [NUM_GROUPS-1:0] irq;
    } grp_t;

    grp_t                s_d, s_q;
    logic [NUM_PINS-1:0] pending;

    assign pending = (pin_adj & level_mask) | (cause & edge_mask);

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_or
        always_comb s_d.irq[g] = |pending[g*GROUP_W +: GROUP_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign grp_irq = s_q.irq;
endmodule

// File: rtl/gpio_irq_agg.sv
module gpio_irq_agg #(
    parameter int NUM_PINS = 32,
    parameter int GROUP_W  = 8,
    parameter int ADDR_W   = 12,
    parameter int MASK_OFS = 0,
    localparam int NUM_GROUPS = NUM_PINS / GROUP_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PINS-1:0]   pin_adj,
    input  logic [NUM_PINS-1:0]   pin_is_in,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [NUM_PINS-1:0]   bus_wdata,
    output logic [NUM_PINS-1:0]   bus_rdata,
    output logic [NUM_GROUPS-1:0] grp_irq
);
    logic                cause_wr;
    logic [NUM_PINS-1:0] cause_vec;
    logic [NUM_PINS-1:0] edge_mask_vec;
    logic [NUM_PINS-1:0] level_mask_vec;

    gpio_irq_regfile #(
        .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .MASK_OFS(MASK_OFS)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .cause_i(cause_vec), .cause_wr_o(cause_wr),
        .edge_mask_o(edge_mask_vec), .level_mask_o(level_mask_vec),
        .bus_rdata(bus_rdata)
    );

    gpio_irq_edge #(.NUM_PINS(NUM_PINS)) u_edge (
        .clk(clk), .rst_n(rst_n),
        .pin_adj(pin_adj), .pin_is_in(pin_is_in),
        .cause_wr(cause_wr), .wr_data(bus_wdata),
        .cause_o(cause_vec)
    );

    gpio_irq_group #(.NUM_PINS(NUM_PINS), .GROUP_W(GROUP_W)) u_grp (
        .clk(clk), .rst_n(rst_n),
        .pin_adj(pin_adj), .level_mask(level_mask_vec),
        .cause(cause_vec), .edge_mask(edge_mask_vec),
        .grp_irq(grp_irq)
    );
endmodule

// File: rtl/gpio_irq_agg_chk.sv
module gpio_irq_agg_chk #(
    parameter int NUM_PINS = 32,
    parameter int GROUP_W  = 8,
    localparam int NUM_GROUPS = NUM_PINS / GROUP_W
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_PINS-1:0]   pin_adj,
    input logic [NUM_PINS-1:0]   pin_is_in,
    input logic                  cause_wr,
    input logic [NUM_PINS-1:0]   cause_vec,
    input logic [NUM_PINS-1:0]   edge_mask_vec,
    input logic [NUM_PINS-1:0]   level_mask_vec,
    input logic [NUM_GROUPS-1:0] grp_irq
);
    logic                armed_q;
    logic [NUM_PINS-1:0] seen_q;
    logic [NUM_PINS-1:0] rise_c;
    logic [NUM_PINS-1:0] pend_c;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            seen_q  <= '0;
        end else begin
            armed_q <= 1'b1;
            seen_q  <= pin_adj;
        end
    end

    assign rise_c = armed_q ? (pin_adj & ~seen_q & pin_is_in) : '0;
    assign pend_c = (pin_adj & level_mask_vec) | (cause_vec & edge_mask_vec);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |-> (grp_irq == '0 && cause_vec == '0));

    assert_edge_latched_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && |rise_c) |=> ((cause_vec & $past(rise_c)) == $past(rise_c)));

    assert_cause_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !cause_wr) |=> ((cause_vec & $past(cause_vec)) == $past(cause_vec)));

    assert_output_no_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |=> ((cause_vec & ~$past(cause_vec) & ~$past(pin_is_in)) == '0));

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_chk
        assert_group_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
            armed_q |=> (grp_irq[g] == $past(|pend_c[g*GROUP_W +: GROUP_W])));
    end
endmodule

bind gpio_irq_agg gpio_irq_agg_chk #(.NUM_PINS(NUM_PINS), .GROUP_W(GROUP_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .pin_adj(pin_adj), .pin_is_in(pin_is_in),
    .cause_wr(cause_wr), .cause_vec(cause_vec),
    .edge_mask_vec(edge_mask_vec), .level_mask_vec(level_mask_vec),
    .grp_irq(grp_irq)
);

// File: tb/gpio_irq_agg_test.sv
module gpio_irq_agg_test;
    localparam int MOFS = 'h40;
    localparam logic [11:0] A_C = 12'h014;
    localparam logic [11:0] A_E = 12'h018 + 12'(MOFS);
    localparam logic [11:0] A_L = 12'h01C + 12'(MOFS);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] adj = '1, dir = '1, wdata = '0;
    logic        wr = 1'b0;
    logic [11:0] addr = A_C;
    logic [31:0] rdata;
    logic [3:0]  irq;

    logic [31:0] m_cause = '0, m_emask = '0, m_lmask = '0, m_prev = '0;
    logic        m_primed = 1'b0;
    logic [3:0]  m_irq = '0;
    int          nchk = 0, nfail = 0;
    string       phase = "R1";
    bit          done = 1'b0;

    always #2 clk = ~clk;

    gpio_irq_agg #(.MASK_OFS(MOFS)) uut (
        .clk(clk), .rst_n(rst_n), .pin_adj(adj), .pin_is_in(dir),
        .bus_wr(wr), .bus_addr(addr), .bus_wdata(wdata),
        .bus_rdata(rdata), .grp_irq(irq)
    );

    function automatic logic [31:0] exp_read(logic [11:0] a);
        if (a == A_C) return m_cause;
        if (a == A_E) return m_emask;
        if (a == A_L) return m_lmask;
        return '0;
    endfunction

    function automatic logic [3:0] exp_groups(logic [31:0] p);
        logic [3:0] g;
        for (int k = 0; k < 4; k++) g[k] = |p[k*8 +: 8];
        return g;
    endfunction

    task automatic check(string what, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %h expected %h", phase, what, act, exp);
        end
    endtask

    task automatic tick();
        logic [31:0] rise, keep, n_cause, n_e, n_l;
        logic [3:0]  g;
        g       = exp_groups((adj & m_lmask) | (m_cause & m_emask));
        rise    = m_primed ? (adj & ~m_prev & dir) : '0;
        keep    = (wr && addr == A_C) ? wdata : '1;
        n_cause = (m_cause & keep) | rise;
        n_e     = (wr && addr == A_E) ? wdata : m_emask;
        n_l     = (wr && addr == A_L) ? wdata : m_lmask;
        @(posedge clk);
        m_cause = n_cause; m_emask = n_e; m_lmask = n_l;
        m_prev = adj; m_primed = 1'b1; m_irq = g;
        @(negedge clk);
        check("grp_irq", 32'(irq), 32'(m_irq));
        check("rdata", rdata, exp_read(addr));
    endtask

    task automatic wr_reg(logic [11:0] a, logic [31:0] d);
        addr = a; wdata = d; wr = 1'b1;
        tick();
        wr = 1'b0;
    endtask

    task automatic idle(int n, logic [11:0] a);
        addr = a;
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        #400000;
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired in phase %s", phase);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("reset irq", 32'(irq), 32'h0);
        check("reset cause", rdata, 32'h0);
        rst_n = 1'b1;
        // R11: input high at release records no edge
        phase = "R11";
        idle(2, A_C);
        adj = '0;
        phase = "R1";
        idle(1, A_E); idle(1, A_L); idle(1, A_C);

        phase = "R2";
        wr_reg(A_E, 32'h0000_0000);
        wr_reg(A_L, 32'h5A5A_0F0F);
        idle(1, A_L);
        wr_reg(12'h020, 32'hFFFF_FFFF);
        wr_reg(12'h018, 32'hFFFF_FFFF);   // unshifted mask offset is unmapped here
        idle(1, A_L); idle(1, 12'h018); idle(1, A_E);
        wr_reg(A_L, 32'h0);

        phase = "R3";
        wr_reg(A_L, 32'h0000_0020);
        adj[5] = 1'b1; idle(3, A_L);
        adj[5] = 1'b0; idle(2, A_L);
        wr_reg(A_L, 32'h0);

        phase = "R4";
        wr_reg(A_E, 32'hFFFF_FFFF);
        adj[12] = 1'b1; idle(2, A_C);
        adj[12] = 1'b0; idle(3, A_C);

        phase = "R5";
        adj[20] = 1'b1; idle(2, A_C);
        wr_reg(A_C, ~32'h0000_1000);
        idle(2, A_C);
        wr_reg(A_C, 32'hFFFF_FFFF);
        idle(1, A_C);
        wr_reg(A_C, 32'h0);
        adj = '0; idle(2, A_C);

        phase = "R6";
        idle(1, A_C);
        adj[3] = 1'b1;
        wr_reg(A_C, 32'h0);
        idle(2, A_C);
        wr_reg(A_C, 32'h0); adj = '0; idle(1, A_C);

        phase = "R7";
        dir[9] = 1'b0;
        adj[9] = 1'b1; idle(2, A_C);
        adj[9] = 1'b0; idle(1, A_C);
        adj[9] = 1'b1; idle(2, A_C);
        adj = '0; dir = '1; idle(1, A_C);

        phase = "R8";
        wr_reg(A_E, ~32'h0200_0000);
        adj[25] = 1'b1; idle(3, A_C);
        wr_reg(A_E, 32'hFFFF_FFFF);
        idle(2, A_C);
        wr_reg(A_C, 32'h0); adj = '0; idle(1, A_C);

        phase = "R9";
        wr_reg(A_L, 32'hFFFF_FFFF);
        for (int b = 0; b < 32; b += 7) begin
            adj = 32'h1 << b; idle(1, A_L);
        end
        adj = 32'h0000_0080; idle(1, A_L);
        adj = 32'h0000_0100; idle(1, A_L);
        adj = 32'h8000_0000; idle(1, A_L);
        adj = '0; wr_reg(A_L, 32'h0); wr_reg(A_C, 32'h0);

        phase = "R10";
        for (int i = 0; i < 3000; i++) begin
            int unsigned r;
            r = $urandom_range(0, 9);
            adj = adj ^ ($urandom() & $urandom() & $urandom());
            if (r == 0) dir = $urandom() | $urandom();
            case ($urandom_range(0, 4))
                0: addr = A_C;
                1: addr = A_E;
                2: addr = A_L;
                3: addr = 12'(MOFS);
                default: addr = 12'($urandom());
            endcase
            wr = ($urandom_range(0, 5) == 0);
            wdata = (addr == A_C) ? ~($urandom() & $urandom()) : $urandom();
            tick();
            wr = 1'b0;
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end
endmodule